// File: doc/BRIEF.md
# Cascaded Tick Timer with Watchdog

This block derives all of its timing from one counter chain. A selectable prescaler divides the clock and feeds an 8-bit base counter. Each wrap of the base counter does one of two things. While the block is in normal operation, it produces a one-cycle periodic interrupt pulse and advances a 3-bit watchdog counter. While the block is warming up after a sleep exit, it marks the end of the oscillator warm-up interval.

When the watchdog counter wraps, the block raises a reset request that lasts a fixed number of cycles. Software prevents this by pulsing the clear input before the watchdog wraps. A disable input stops the watchdog path and leaves the periodic interrupt running.

Top module: `cascade_tick_wdt`

## Requirements
- R1: While `rst_n` is low and after it rises, `tick_irq` is 0, `warm_done` is 1 and `wdt_rst_req` is 0.
- R2: `div_sel` picks the prescale ratio: 0 divides by 1, 1 by 8, 2 by 64 and 3 by 256. After a clear, the first base-counter wrap comes 256 times the ratio clock cycles after the clearing edge.
- R3: On each base-counter wrap outside warm-up, `tick_irq` is high for exactly one cycle.
- R4: A one-cycle `clr` zeroes the prescaler, the base counter and the watchdog counter at the same edge. The next wrap is timed from that edge, and a watchdog reset that was about to fire is cancelled.
- R5: The watchdog counts base-counter wraps. On the 8th counted wrap after a clear it wraps, and `wdt_rst_req` goes high at that same edge and stays high for 4 cycles.
- R6: While `wdt_dis` is 1, the watchdog counter does not advance and `wdt_rst_req` does not rise. `tick_irq` pulses are not affected.
- R7: A one-cycle `wake` zeroes the prescaler and the base counter and drives `warm_done` low. `warm_done` goes high at the next base-counter wrap, and that wrap gives no `tick_irq` pulse.
- R8: During warm-up the watchdog counter holds its value. The wrap that ends warm-up is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_sel | input | 2 | Prescale ratio select |
| clr | input | 1 | Software clear pulse for the counters |
| wdt_dis | input | 1 | Watchdog disable |
| wake | input | 1 | Sleep-exit request; starts warm-up |
| tick_irq | output | 1 | Periodic interrupt pulse |
| warm_done | output | 1 | Low while warm-up is in progress |
| wdt_rst_req | output | 1 | Watchdog reset request, 4 cycles long |

## Verification
The periodic tick is measured from a clear under each of the four prescale ratios. Because each ratio gives a distinct wrap distance, a wrong select decode or a wrong tap produces a different measured period.

The watchdog is tested in four ways:
- It runs freely to its eighth wrap.
- It is cleared just before firing, which separates a cleared count from a stale one.
- It runs with the disable set, which checks that interrupts continue while resets are blocked.
- It is interrupted by a wake when its count is one short of firing. Here the reset edge shows whether the warm-up wrap was wrongly counted.

// File: rtl/cascade_tick_pkg.sv
package cascade_tick_pkg;
    typedef enum logic [1:0] {
        DIV_1   = 2'd0,
        DIV_8   = 2'd1,
        DIV_64  = 2'd2,
        DIV_256 = 2'd3
    } div_sel_e;

    typedef struct packed {
        logic irq;
        logic warm;
    } top_state_t;

    localparam int SEL_STEP = 3;
endpackage

// File: rtl/cascade_prescaler.sv
module cascade_prescaler
    import cascade_tick_pkg::*;
#(
    parameter int PRE_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] div_sel,
    input  logic       restart,
    output logic       tick
);
    logic [PRE_W-1:0] pre_d, pre_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        int sh;
        sh = SEL_STEP * int'(div_sel);
        if (sh > PRE_W) sh = PRE_W;
        mask  = PRE_W'((33'd1 << sh) - 33'd1);
        tick  = ((pre_q & mask) == mask) && !restart;
        pre_d = restart ? '0 : pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    p_restart_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (pre_q == '0));
endmodule

// File: rtl/cascade_base_counter.sv
module cascade_base_counter #(
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic restart,
    output logic wrap
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } base_state_t;

    base_state_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        wrap = tick && !restart && (s_q.cnt == '1);
        if (restart)   s_d.cnt = '0;
        else if (tick) s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    p_no_wrap_on_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (s_q.cnt == '0));
endmodule

// File: rtl/cascade_watchdog.sv
module cascade_watchdog #(
    parameter int WD_W      = 3,
    parameter int PULSE_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic count_en,
    input  logic clr,
    output logic rst_req
);
    localparam int HOLD_W = $clog2(PULSE_LEN + 1);

    typedef struct packed {
        logic [WD_W-1:0]   cnt;
        logic [HOLD_W-1:0] hold;
    } wd_state_t;

    wd_state_t s_d, s_q;
    logic step, fire;

    always_comb begin
        s_d  = s_q;
        step = wrap && count_en && !clr;
        fire = step && (s_q.cnt == '1);
        if (clr)       s_d.cnt = '0;
        else if (step) s_d.cnt = s_q.cnt + 1'b1;
        if (fire)                 s_d.hold = HOLD_W'(PULSE_LEN);
        else if (s_q.hold != '0)  s_d.hold = s_q.hold - 1'b1;
        rst_req = (s_q.hold != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    p_frozen_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_en && !clr) |=> $stable(s_q.cnt));
    p_pulse_min_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |=> rst_req);
    p_no_fire_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_en && !rst_req) |=> !rst_req);
endmodule

// File: rtl/cascade_tick_wdt.sv
module cascade_tick_wdt
    import cascade_tick_pkg::*;
#(
    parameter int PRE_W     = 8,
    parameter int CNT_W     = 8,
    parameter int WD_W      = 3,
    parameter int PULSE_LEN = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] div_sel,
    input  logic       clr,
    input  logic       wdt_dis,
    input  logic       wake,
    output logic       tick_irq,
    output logic       warm_done,
    output logic       wdt_rst_req
);
    logic restart, tick, wrap;
    top_state_t s_d, s_q;

    assign restart = clr || wake;

    cascade_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel),
        .restart(restart), .tick(tick)
    );

    cascade_base_counter #(.CNT_W(CNT_W)) u_base (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .restart(restart), .wrap(wrap)
    );

    cascade_watchdog #(.WD_W(WD_W), .PULSE_LEN(PULSE_LEN)) u_wd (
        .clk(clk), .rst_n(rst_n), .wrap(wrap),
        .count_en(s_q.warm && !wdt_dis), .clr(clr),
        .rst_req(wdt_rst_req)
    );

    always_comb begin
        s_d     = s_q;
        s_d.irq = wrap && s_q.warm;
        if (wake)      s_d.warm = 1'b0;
        else if (wrap) s_d.warm = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{irq: 1'b0, warm: 1'b1};
        else        s_q <= s_d;
    end

    assign tick_irq  = s_q.irq;
    assign warm_done = s_q.warm;

    p_irq_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_irq |=> !tick_irq);
    p_warm_no_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !warm_done |=> !tick_irq);
    p_clr_no_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !tick_irq);
    p_wake_starts_warm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> !warm_done);
endmodule

// File: tb/tb_cascade_tick_wdt.sv
module tb_cascade_tick_wdt;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    typedef struct packed {
        logic [1:0]  sel;
        logic [17:0] period;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{sel: 2'd2, period: 18'd16384},
        '{sel: 2'd0, period: 18'd256},
        '{sel: 2'd3, period: 18'd65536},
        '{sel: 2'd1, period: 18'd2048}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] div_sel = 2'd0;
    logic clr = 1'b0, wdt_dis = 1'b0, wake = 1'b0;
    logic tick_irq, warm_done, wdt_rst_req;

    int n_chk = 0, n_bad = 0, k = 0, cyc = 0;
    bit done = 1'b0;

    cascade_tick_wdt dut (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .clr(clr),
        .wdt_dis(wdt_dis), .wake(wake), .tick_irq(tick_irq),
        .warm_done(warm_done), .wdt_rst_req(wdt_rst_req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (k=%0d)", tag, act, exp, k);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WATCHDOG);
            finish_run();
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_clr();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        k = 0;
    endtask

    task automatic pulse_wake();
        @(negedge clk); wake = 1'b1;
        @(negedge clk); wake = 1'b0;
        k = 0;
    endtask

    task automatic step_to(input int target);
        while (k < target) begin @(negedge clk); k++; end
    endtask

    initial begin
        int first;
        int rst_hi, irq_cnt, irq256;
        // R1: reset state
        idle(2);
        chk(tick_irq, 0, "R1 irq in reset");
        chk(warm_done, 1, "R1 warm in reset");
        chk(wdt_rst_req, 0, "R1 rst_req in reset");
        rst_n = 1'b1;
        idle(3);
        chk(tick_irq, 0, "R1 irq after reset");
        chk(warm_done, 1, "R1 warm after reset");
        chk(wdt_rst_req, 0, "R1 rst_req after reset");

        // R2/R3: period table
        foreach (VEC[i]) begin
            idle(6);
            @(negedge clk); div_sel = VEC[i].sel;
            pulse_clr();
            first = -1;
            while (first < 0 && k <= int'(VEC[i].period) + 8) begin
                @(negedge clk); k++;
                if (tick_irq) first = k;
            end
            chk(first, int'(VEC[i].period), "R2 wrap period");
            @(negedge clk); k++;
            chk(tick_irq, 0, "R3 irq one cycle");
        end

        // R5: free-running watchdog
        idle(8);
        @(negedge clk); div_sel = 2'd0; wdt_dis = 1'b0;
        pulse_clr();
        step_to(2047);
        chk(wdt_rst_req, 0, "R5 rst before 8th wrap");
        step_to(2048);
        chk(wdt_rst_req, 1, "R5 rst at 8th wrap");
        chk(tick_irq, 1, "R3 irq at 8th wrap");
        step_to(2051);
        chk(wdt_rst_req, 1, "R5 rst last cycle");
        step_to(2052);
        chk(wdt_rst_req, 0, "R5 rst released");

        // R4: clear before firing
        idle(8);
        pulse_clr();
        step_to(2000);
        pulse_clr();
        rst_hi = 0; irq256 = 0;
        while (k < 2047) begin
            @(negedge clk); k++;
            if (wdt_rst_req) rst_hi++;
            if (k == 256) irq256 = tick_irq;
        end
        chk(rst_hi, 0, "R4 cleared watchdog no reset");
        chk(irq256, 1, "R4 wrap timed from clear");
        step_to(2048);
        chk(wdt_rst_req, 1, "R4 reset after full count");

        // R6: disable
        idle(8);
        @(negedge clk); wdt_dis = 1'b1;
        pulse_clr();
        rst_hi = 0; irq_cnt = 0;
        while (k < 2100) begin
            @(negedge clk); k++;
            if (wdt_rst_req) rst_hi++;
            if (tick_irq) irq_cnt++;
        end
        chk(rst_hi, 0, "R6 no reset when disabled");
        chk(irq_cnt, 8, "R6 irq continues when disabled");

        // R7/R8: warm-up
        idle(8);
        @(negedge clk); wdt_dis = 1'b0;
        pulse_clr();
        step_to(1800);
        pulse_wake();
        chk(warm_done, 0, "R7 warm low after wake");
        step_to(255);
        chk(warm_done, 0, "R7 warm low before wrap");
        step_to(256);
        chk(warm_done, 1, "R7 warm high at wrap");
        chk(tick_irq, 0, "R7 no irq on warm wrap");
        chk(wdt_rst_req, 0, "R8 warm wrap not counted");
        step_to(512);
        chk(tick_irq, 1, "R3 irq after warm-up");
        chk(wdt_rst_req, 1, "R8 reset on next counted wrap");

        done = 1'b1;
        finish_run();
    end
endmodule